// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block models one logic cell of a programmable fabric. A 16-entry truth table addresses any Boolean function of four inputs. A per-cell storage element can drive the cell output, or it can be bypassed. A carry input and a carry output let adjacent cells form a ripple adder. A neighbour input lets a cell's storage element take its value from the next cell, so that a row of cells forms a wide register or a shift chain. The cell runs in one of two modes. In logic mode the full table is used. In arithmetic mode the table splits into two 8-entry halves, one for the sum and one for the carry.

The table and the three mode bits are held in a 19-bit configuration word. The word is shifted in one bit per clock while the load strobe is high. The storage is volatile: reset wipes it. Every output stays at zero until a complete load session has finished.

Top module: `lut_cell`

## Requirements
- R1: While `cfg_en` is 1, each clock shifts `cfg_din` into bit 18 of the configuration word and moves the other bits one place down, so the first of 19 bits sent ends in bit 0. Word layout: bits 15..0 are the truth table, bit 16 selects arithmetic mode, bit 17 selects the neighbour input as register source, and bit 18 selects the registered output.
- R2: `le_out`, `reg_q` and `cout` are 0 while `cfg_en` is 1. They also stay 0 until a session of at least 19 consecutive `cfg_en` cycles has completed since reset. A shorter session leaves them at 0 again.
- R3: Synchronous reset `rst` erases the configuration and the loaded state, so all outputs return to 0 until the word is loaded again.
- R4: In logic mode (bit 16 = 0) the cell value is table bit `{ins[3],ins[2],ins[1],ins[0]}`.
- R5: In arithmetic mode the cell value (sum) is table bit `{cin,ins[1],ins[0]}` and `cout` is table bit `8 + {cin,ins[1],ins[0]}`. `ins[3]` and `ins[2]` have no effect.
- R6: In logic mode `cout` is 0.
- R7: When loaded, the register takes its data input at a clock edge where `ena` is 1, and keeps its value when `ena` is 0.
- R8: The register data input is `chain_in` when bit 17 is 1, and the cell value when it is 0.
- R9: `le_out` equals `reg_q` when bit 18 is 1 and the cell value when it is 0. `reg_q` always shows the register.
- R10: `aclr` = 1 clears the register at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; erases configuration |
| cfg_en | input | 1 | Configuration shift strobe |
| cfg_din | input | 1 | Serial configuration bit |
| aclr | input | 1 | Asynchronous register clear, active high |
| ena | input | 1 | Register load enable |
| ins | input | 4 | Table address inputs |
| cin | input | 1 | Carry from the previous cell |
| chain_in | input | 1 | Register value from the neighbouring cell |
| le_out | output | 1 | Cell output (combinational or registered) |
| reg_q | output | 1 | Register output, for the next cell's chain input |
| cout | output | 1 | Carry to the next cell |

## Verification
The hardest state to reach from the ports is a cell that was fully loaded and then had a new load session started and cut short. The counter must restart, and the outputs must fall to zero and stay there. The bench gets there by loading a valid word, observing live outputs, and then issuing a shorter session of a few strobe cycles. Checking that the upper inputs are ignored in arithmetic mode needs every sum and carry index swept under each value of `ins[3:2]`, which the arithmetic task does.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int LE_LUT_K  = 4;
  localparam int LE_TBL_W  = 1 << LE_LUT_K;
  localparam int LE_CFG_W  = LE_TBL_W + 3;
  localparam int LE_CNT_W  = $clog2(LE_CFG_W + 1);

  typedef struct packed {
    logic                out_reg;
    logic                chain_sel;
    logic                arith;
    logic [LE_TBL_W-1:0] table_bits;
  } le_cfg_t;
endpackage

// File: rtl/lut_cell_cfg.sv
module lut_cell_cfg
  import lut_cell_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cfg_en,
  input  logic    cfg_din,
  output le_cfg_t cfg_q,
  output logic    ready
);
  logic [LE_CFG_W-1:0] word_q;
  logic [LE_CNT_W-1:0] cnt_q;
  logic                en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= cfg_en;
      if (cfg_en) begin
        word_q <= {cfg_din, word_q[LE_CFG_W-1:1]};
        if (!en_q)
          cnt_q <= LE_CNT_W'(1);
        else if (cnt_q != LE_CNT_W'(LE_CFG_W))
          cnt_q <= cnt_q + LE_CNT_W'(1);
      end
    end
  end

  assign cfg_q = le_cfg_t'(word_q);
  assign ready = !cfg_en && (cnt_q == LE_CNT_W'(LE_CFG_W));

  // R1: configuration is frozen outside a load session
  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(word_q));
endmodule

// File: rtl/lut_cell_eval.sv
module lut_cell_eval
  import lut_cell_pkg::*;
(
  input  le_cfg_t             cfg,
  input  logic [LE_LUT_K-1:0] ins,
  input  logic                cin,
  output logic                value,
  output logic                carry
);
  localparam int HALF_W = LE_LUT_K - 1;

  logic [HALF_W-1:0] half_idx;

  always_comb begin
    half_idx = {cin, ins[LE_LUT_K-3:0]};
    if (cfg.arith) begin
      value = cfg.table_bits[{1'b0, half_idx}];
      carry = cfg.table_bits[{1'b1, half_idx}];
    end else begin
      value = cfg.table_bits[ins];
      carry = 1'b0;
    end
  end
endmodule

// File: rtl/lut_cell_reg.sv
module lut_cell_reg (
  input  logic clk,
  input  logic rst,
  input  logic aclr,
  input  logic ld_ok,
  input  logic ena,
  input  logic sel_chain,
  input  logic chain_in,
  input  logic lut_val,
  output logic q
);
  logic d;
  assign d = sel_chain ? chain_in : lut_val;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)        q <= 1'b0;
    else if (rst)    q <= 1'b0;
    else if (!ld_ok) q <= 1'b0;
    else if (ena)    q <= d;
  end

  // R7: a disabled register keeps its value
  a_r7_hold: assert property (@(posedge clk) disable iff (rst || aclr)
    (ld_ok && !ena) |=> $stable(q));
  // R8: neighbour input is captured when selected
  a_r8_chain_load: assert property (@(posedge clk) disable iff (rst || aclr)
    (ld_ok && ena && sel_chain) |=> (q == $past(chain_in)));
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_en,
  input  logic                cfg_din,
  input  logic                aclr,
  input  logic                ena,
  input  logic [LE_LUT_K-1:0] ins,
  input  logic                cin,
  input  logic                chain_in,
  output logic                le_out,
  output logic                reg_q,
  output logic                cout
);
  le_cfg_t cfg;
  logic    ready;
  logic    lut_val;
  logic    lut_carry;
  logic    q;

  lut_cell_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_q(cfg), .ready(ready)
  );

  lut_cell_eval u_eval (
    .cfg(cfg), .ins(ins), .cin(cin), .value(lut_val), .carry(lut_carry)
  );

  lut_cell_reg u_reg (
    .clk(clk), .rst(rst), .aclr(aclr), .ld_ok(ready), .ena(ena),
    .sel_chain(cfg.chain_sel), .chain_in(chain_in), .lut_val(lut_val),
    .q(q)
  );

  assign reg_q  = ready ? q : 1'b0;
  assign cout   = ready ? lut_carry : 1'b0;
  assign le_out = !ready ? 1'b0 : (cfg.out_reg ? q : lut_val);

  // R2: outputs quiet until a full load session
  a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (le_out == 1'b0 && reg_q == 1'b0 && cout == 1'b0));
  // R9: registered output mirrors the register
  a_r9_regout: assert property (@(posedge clk) disable iff (rst)
    (ready && cfg.out_reg) |-> (le_out == reg_q));
endmodule

// File: tb/tb_lut_cell.sv
module tb_lut_cell;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0, cfg_din = 1'b0, aclr = 1'b0, ena = 1'b0;
  logic [3:0] ins = '0;
  logic cin = 1'b0, chain_in = 1'b0;
  logic le_out, reg_q, cout;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  lut_cell dut (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .aclr(aclr), .ena(ena), .ins(ins), .cin(cin), .chain_in(chain_in),
    .le_out(le_out), .reg_q(reg_q), .cout(cout));

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] tbl, input logic ar, input logic ch,
                      input logic ro, input int nbits);
    logic [18:0] w;
    w = {ro, ch, ar, tbl};
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); cfg_en = 1'b1; cfg_din = w[i];
      #1 check(le_out | reg_q | cout, 1'b0, "R2 outputs zero during load");
    end
    @(negedge clk); cfg_en = 1'b0; #1;
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b0; #1;
    check(le_out, 1'b0, "R3 le_out after reset");
    check(reg_q, 1'b0, "R3 reg_q after reset");
    check(cout, 1'b0, "R3 cout after reset");
  endtask

  task automatic t_normal(input logic [15:0] tbl);
    load(tbl, 1'b0, 1'b0, 1'b0, 19);
    for (int v = 0; v < 16; v++) begin
      ins = 4'(v); cin = v[0]; #1;
      check(le_out, tbl[v], $sformatf("R4 logic idx %0d", v));
      check(cout, 1'b0, "R6 no carry in logic mode");
    end
  endtask

  task automatic t_arith;
    logic [15:0] tbl;
    tbl = 16'hE896;  // low half a^b^c, high half majority
    load(tbl, 1'b1, 1'b0, 1'b0, 19);
    for (int v = 0; v < 32; v++) begin
      logic a, b, c;
      a = v[0]; b = v[1]; c = v[2];
      ins = {v[4], v[3], b, a}; cin = c; #1;
      check(le_out, a ^ b ^ c, $sformatf("R5 sum v=%0d", v));
      check(cout, (a & b) | (a & c) | (b & c), $sformatf("R5 carry v=%0d", v));
    end
  endtask

  task automatic t_register;
    load(16'h6996, 1'b0, 1'b0, 1'b1, 19);
    @(negedge clk); ins = 4'b0001; ena = 1'b1;
    @(negedge clk); check(reg_q, 1'b1, "R7 load on enable");
    check(le_out, 1'b1, "R9 registered output");
    ena = 1'b0; ins = 4'b0011;
    @(negedge clk); check(reg_q, 1'b1, "R7 hold when disabled");
    check(le_out, 1'b1, "R9 registered output ignores table");
    ena = 1'b1;
    @(negedge clk); check(reg_q, 1'b0, "R7 reload");
    ins = 4'b0111;
    @(negedge clk); check(reg_q, 1'b1, "R7 reload high");
    #2 aclr = 1'b1; #1;
    check(reg_q, 1'b0, "R10 asynchronous clear");
    aclr = 1'b0; ena = 1'b0;
    @(negedge clk); check(reg_q, 1'b0, "R10 stays cleared");
  endtask

  task automatic t_chain;
    load(16'h0000, 1'b0, 1'b1, 1'b0, 19);
    @(negedge clk); ena = 1'b1; chain_in = 1'b1;
    @(negedge clk); check(reg_q, 1'b1, "R8 chain load");
    check(le_out, 1'b0, "R9 bypass shows table value");
    chain_in = 1'b0;
    @(negedge clk); check(reg_q, 1'b0, "R8 chain load zero");
    ena = 1'b0;
  endtask

  task automatic t_short_session;
    load(16'hFFFF, 1'b0, 1'b0, 1'b0, 19);
    check(le_out, 1'b1, "R1 full word live");
    load(16'hFFFF, 1'b0, 1'b0, 1'b0, 7);
    check(le_out, 1'b0, "R2 short session leaves outputs zero");
  endtask

  task automatic t_order;
    // only bit 0 set: function true for index 0 only
    load(16'h0001, 1'b0, 1'b0, 1'b0, 19);
    ins = 4'd0; #1 check(le_out, 1'b1, "R1 first bit lands at bit 0");
    ins = 4'd15; #1 check(le_out, 1'b0, "R1 bit 15 clear");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; ins = 4'd0; #1;
    check(le_out, 1'b0, "R3 reset erases configuration");
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog all-reqs actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_normal(16'h6996);
    t_normal(16'h8000);
    t_arith();
    t_register();
    t_chain();
    t_short_session();
    t_order();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule